// File: doc/BRIEF.md
# General-Purpose I/O Port with Analog Read Masking

This block is one bidirectional general-purpose I/O port for a small microcontroller. It holds three registers: a direction register (1 = input, driver released; 0 = output), an output data latch and an analog-select mask. A simple single-cycle bus reaches these registers through a two-bit select. Reads of the data select return the levels actually present on the pins, not the latch. Those levels pass through a two-flop synchroniser first. Any bit selected as analog reads as zero.

A separate bit set/clear path changes one latch bit in one cycle. It samples the live (synchronised, analog-masked) pin levels, changes the chosen bit and writes the whole word back to the latch. Pins chosen by a parameter mask are open-drain: they can only pull low and release when their latch bit is 1. A per-pin peripheral override hands a pin's enable and value to another block, and while it is active the port's own settings for that pin have no effect.

Top module: `gpio_port`

## Requirements
- R1: Synchronous reset sets the direction register to all ones, clears the latch, sets the analog mask to the analog-capable set `ANA_CAP` (default 6'b101111), and leaves every non-overridden pin with its output enable low.
- R2: A push-pull pin with direction bit 0 has `pin_oe`=1 and `pin_out` equal to its latch bit; with direction bit 1 it has `pin_oe`=0. The change appears one clock after the direction write.
- R3: A read with `bus_addr`=0 returns the pin level after a two-flop synchroniser and a registered read stage, not the latch. A pin change seen before clock edge k appears on `bus_rdata` after edge k+2.
- R4: Every bit set in the analog mask reads as 0 on a data read, whatever level its pin has.
- R5: Only bits inside `ANA_CAP` can be set in the analog mask. Other bits always stay 0.
- R6: A bus write with `bus_addr`=0 loads the latch, 1 loads the direction register and 2 loads the analog mask. Select 3 changes nothing and reads 0. Reads of selects 1 and 2 return the register contents one clock later.
- R7: A bit operation (`bit_en`=1; `bit_set`=1 sets, 0 clears) writes to the latch the live analog-masked pin levels, with bit `bit_idx` forced to the requested value.
- R8: A bit operation with `bit_idx` below the port width takes priority over a bus write in the same cycle, and that write is dropped. A bit operation with `bit_idx` at or above the width does nothing.
- R9: An open-drain pin (bit set in `OD_MASK`, default bit 4) always outputs 0. Its `pin_oe` is 1 only when its direction bit is 0 and its latch bit is 0.
- R10: With `alt_en[i]`=1, `pin_oe[i]` equals `alt_oe[i]` and `pin_out[i]` equals `alt_out[i]`. Direction, latch and open-drain settings are ignored for that pin.
- R11: The direction register still controls a pin that is selected as analog. An analog pin with direction bit 0 keeps driving its latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 data, 1 direction, 2 analog mask, 3 unused |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data of the selected register |
| bit_en | input | 1 | Start a single-bit set/clear on the latch |
| bit_set | input | 1 | 1 sets the chosen bit, 0 clears it |
| bit_idx | input | IDXW | Index of the bit to change |
| pin_in | input | W | Levels sensed on the pads |
| pin_oe | output | W | Per-pin output enable |
| pin_out | output | W | Per-pin output value |
| alt_en | input | W | Per-pin peripheral override enable |
| alt_oe | input | W | Peripheral output enable |
| alt_out | input | W | Peripheral output value |

## Verification
The bench drives the pins so that their levels differ from the latch. A design that read the latch, or one that did not mask analog bits, would return the wrong data word. Bit set/clear is run with pins held at a pattern unrelated to the latch, including one case with an analog bit selected. A design that modified the latch itself, or that ignored the analog mask, would leave a different word on `pin_out` once the direction is switched to output. The open-drain pin is released with the modelled pull-up and then held low from outside, which catches a design that drives it high. The bench also issues a bit operation in the same cycle as a write, and a bit operation with an out-of-range index; a design with the wrong priority, or one that wraps the index, would corrupt the latch.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Register select codes seen on the bus
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_ANA  = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    // Latch-affecting operation resolved for one cycle
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_LOAD = 2'd1,
        OP_BSET = 2'd2,
        OP_BCLR = 2'd3
    } op_e;

    typedef struct packed {
        op_e  op;
        sel_e sel;
    } bus_cmd_t;

    // A valid bit operation outranks a plain register write
    function automatic op_e decode_op(input logic wr, input logic bit_go,
                                      input logic bit_hi, input logic idx_ok);
        if (bit_go && idx_ok) return bit_hi ? OP_BSET : OP_BCLR;
        if (wr)               return OP_LOAD;
        return OP_IDLE;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= raw;
            stage2 <= stage1;
        end
    end

    assign lvl = stage2;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int             W       = 6,
    parameter int             IDXW    = 3,
    parameter logic [W-1:0]   ANA_CAP = 6'b101111
) (
    input  logic            clk,
    input  logic            rst,
    input  bus_cmd_t        cmd,
    input  logic [W-1:0]    wdata,
    input  logic [IDXW-1:0] bit_idx,
    input  logic [W-1:0]    lvl,
    output logic [W-1:0]    dir_q,
    output logic [W-1:0]    lat_q,
    output logic [W-1:0]    ana_q,
    output logic [W-1:0]    rdata
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] live;
    logic [W-1:0] pick;
    logic [W-1:0] rd_next;

    assign live = lvl & ~ana_q;
    assign pick = ONE << bit_idx;

    always_comb begin
        case (cmd.sel)
            SEL_DATA: rd_next = live;
            SEL_DIR:  rd_next = dir_q;
            SEL_ANA:  rd_next = ana_q;
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '1;
            lat_q <= '0;
            ana_q <= ANA_CAP;
            rdata <= '0;
        end else begin
            case (cmd.op)
                OP_LOAD: begin
                    case (cmd.sel)
                        SEL_DATA: lat_q <= wdata;
                        SEL_DIR:  dir_q <= wdata;
                        SEL_ANA:  ana_q <= wdata & ANA_CAP;
                        default:  ;
                    endcase
                end
                OP_BSET: lat_q <= live | pick;
                OP_BCLR: lat_q <= live & ~pick;
                default: ;
            endcase
            rdata <= rd_next;
        end
    end

    // R1: reset values
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (dir_q == '1 && lat_q == '0 && ana_q == ANA_CAP));

    // R6: data load reaches the latch
    assert_load_latch_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_LOAD && cmd.sel == SEL_DATA) |=> lat_q == $past(wdata));

    // R5: mask never holds a non-capable bit
    assert_ana_cap_R5: assert property (@(posedge clk) disable iff (rst)
        (ana_q & ~ANA_CAP) == '0);

    // R4: analog bits read zero
    assert_ana_read_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd.sel == SEL_DATA) |=> (rdata & $past(ana_q)) == '0);

    // R7: chosen bit ends up set / cleared
    assert_bit_set_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_BSET) |=> |(lat_q & $past(pick)));
    assert_bit_clr_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_BCLR) |=> !(|(lat_q & $past(pick))));
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
    parameter int           W       = 6,
    parameter logic [W-1:0] OD_MASK = 6'b010000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] lat_q,
    input  logic [W-1:0] alt_en,
    input  logic [W-1:0] alt_oe,
    input  logic [W-1:0] alt_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out
);
    logic [W-1:0] own_oe;
    logic [W-1:0] own_out;

    for (genvar i = 0; i < W; i++) begin : g_pin
        if (OD_MASK[i]) begin : g_od
            assign own_oe[i]  = ~dir_q[i] & ~lat_q[i];
            assign own_out[i] = 1'b0;

            // R9: open-drain pin never drives high
            assert_od_low_R9: assert property (@(posedge clk) disable iff (rst)
                (!alt_en[i] && pin_oe[i]) |-> !pin_out[i]);
        end else begin : g_pp
            assign own_oe[i]  = ~dir_q[i];
            assign own_out[i] = lat_q[i];
        end

        assign pin_oe[i]  = alt_en[i] ? alt_oe[i]  : own_oe[i];
        assign pin_out[i] = alt_en[i] ? alt_out[i] : own_out[i];

        // R2: an input pin is released unless a peripheral owns it
        assert_input_release_R2: assert property (@(posedge clk) disable iff (rst)
            (!alt_en[i] && dir_q[i]) |-> !pin_oe[i]);
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int           W       = 6,
    parameter logic [W-1:0] OD_MASK = 6'b010000,
    parameter logic [W-1:0] ANA_CAP = 6'b101111,
    localparam int          IDXW    = (W > 1) ? $clog2(W) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      bus_addr,
    input  logic            bus_wr,
    input  logic [W-1:0]    bus_wdata,
    output logic [W-1:0]    bus_rdata,
    input  logic            bit_en,
    input  logic            bit_set,
    input  logic [IDXW-1:0] bit_idx,
    input  logic [W-1:0]    pin_in,
    output logic [W-1:0]    pin_oe,
    output logic [W-1:0]    pin_out,
    input  logic [W-1:0]    alt_en,
    input  logic [W-1:0]    alt_oe,
    input  logic [W-1:0]    alt_out
);
    logic         idx_ok;
    bus_cmd_t     cmd;
    logic [W-1:0] lvl;
    logic [W-1:0] dir_q;
    logic [W-1:0] lat_q;
    logic [W-1:0] ana_q;

    assign idx_ok  = (32'(bit_idx) < W);
    assign cmd.op  = decode_op(bus_wr, bit_en, bit_set, idx_ok);
    assign cmd.sel = sel_e'(bus_addr);

    gpio_sync #(.W(W)) u_sync (
        .clk (clk),
        .rst (rst),
        .raw (pin_in),
        .lvl (lvl)
    );

    gpio_regs #(.W(W), .IDXW(IDXW), .ANA_CAP(ANA_CAP)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .wdata   (bus_wdata),
        .bit_idx (bit_idx),
        .lvl     (lvl),
        .dir_q   (dir_q),
        .lat_q   (lat_q),
        .ana_q   (ana_q),
        .rdata   (bus_rdata)
    );

    gpio_drive #(.W(W), .OD_MASK(OD_MASK)) u_drive (
        .clk     (clk),
        .rst     (rst),
        .dir_q   (dir_q),
        .lat_q   (lat_q),
        .alt_en  (alt_en),
        .alt_oe  (alt_oe),
        .alt_out (alt_out),
        .pin_oe  (pin_oe),
        .pin_out (pin_out)
    );

    // R8: an out-of-range bit operation leaves the latch as it was
    assert_bad_idx_R8: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !idx_ok && !bus_wr) |=> $stable(lat_q));
endmodule

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
    localparam int W = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [5:0] bus_wdata = '0;
    logic [5:0] bus_rdata;
    logic       bit_en = 1'b0;
    logic       bit_set = 1'b0;
    logic [2:0] bit_idx = '0;
    logic [5:0] pin_in;
    logic [5:0] pin_oe;
    logic [5:0] pin_out;
    logic [5:0] alt_en = '0;
    logic [5:0] alt_oe = '0;
    logic [5:0] alt_out = '0;
    logic [5:0] ext_en = '0;
    logic [5:0] ext_val = '0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    // pad model: own driver, else outside driver, else pull-up
    always_comb begin
        for (int i = 0; i < W; i++)
            pin_in[i] = pin_oe[i] ? pin_out[i] : (ext_en[i] ? ext_val[i] : 1'b1);
    end

    gpio_port uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bit_en(bit_en),
        .bit_set(bit_set), .bit_idx(bit_idx), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .alt_en(alt_en),
        .alt_oe(alt_oe), .alt_out(alt_out)
    );

    typedef struct packed {
        logic [1:0] waddr;
        logic [5:0] wdata;
        logic [1:0] raddr;
        logic [5:0] exp;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{2'd1, 6'h15, 2'd1, 6'h15},
        '{2'd2, 6'h3F, 2'd2, 6'h2F},
        '{2'd2, 6'h12, 2'd2, 6'h02},
        '{2'd3, 6'h3F, 2'd3, 6'h00},
        '{2'd1, 6'h2A, 2'd1, 6'h2A},
        '{2'd2, 6'h00, 2'd2, 6'h00},
        '{2'd1, 6'h3F, 2'd1, 6'h3F}
    };

    task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [5:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [5:0] d);
        @(negedge clk);
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic bitop(input logic s, input logic [2:0] idx);
        @(negedge clk);
        bit_en = 1'b1; bit_set = s; bit_idx = idx;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    initial begin
        #1ms;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [5:0] d;
        step(3);
        rst = 1'b0;
        step(1);

        // R1: reset state
        chk("R1 oe", pin_oe, 6'h00);
        rd_reg(2'd1, d); chk("R1 dir", d, 6'h3F);
        rd_reg(2'd2, d); chk("R1 ana", d, 6'h2F);
        step(2);
        rd_reg(2'd0, d); chk("R1 R4 data", d, 6'h10);

        // R5 R6: register table
        for (int k = 0; k < 7; k++) begin
            wr_reg(VECS[k].waddr, VECS[k].wdata);
            rd_reg(VECS[k].raddr, d);
            chk($sformatf("R5/R6 vec %0d", k), d, VECS[k].exp);
        end

        // R1: latch cleared by reset
        wr_reg(2'd1, 6'h00);
        chk("R1 latch out", pin_out, 6'h00);
        chk("R1 latch oe", pin_oe, 6'h3F);

        // R2: push-pull drive, R3 read back
        wr_reg(2'd0, 6'h2A);
        chk("R2 out", pin_out, 6'h2A);
        chk("R2 oe", pin_oe, 6'h3F);
        step(3);
        rd_reg(2'd0, d); chk("R3 driven", d, 6'h2A);

        // R9: open-drain release and external low
        wr_reg(2'd0, 6'h3F);
        chk("R9 oe", pin_oe, 6'h2F);
        chk("R9 out", pin_out, 6'h2F);
        step(3);
        rd_reg(2'd0, d); chk("R9 pullup", d, 6'h3F);
        ext_en = 6'h10; ext_val = 6'h00;
        step(3);
        rd_reg(2'd0, d); chk("R9 ext low", d, 6'h2F);

        // R3: pins, not latch
        wr_reg(2'd1, 6'h3F);
        chk("R2 released", pin_oe, 6'h00);
        ext_en = 6'h3F; ext_val = 6'h05;
        step(3);
        rd_reg(2'd0, d); chk("R3 pins", d, 6'h05);

        // R4: analog masking
        ext_val = 6'h3F;
        wr_reg(2'd2, 6'h2F);
        step(3);
        rd_reg(2'd0, d); chk("R4 analog zero", d, 6'h10);
        wr_reg(2'd2, 6'h00);

        // R7: set from live pins
        ext_val = 6'h0C;
        step(3);
        bitop(1'b1, 3'd0);
        wr_reg(2'd1, 6'h00);
        chk("R7 set out", pin_out, 6'h0D);

        // R7: clear from live pins
        wr_reg(2'd1, 6'h3F);
        ext_val = 6'h3F;
        step(3);
        bitop(1'b0, 3'd5);
        wr_reg(2'd1, 6'h00);
        chk("R7 clr out", pin_out, 6'h0F);
        chk("R7 clr oe", pin_oe, 6'h2F);

        // R7 with analog bit, R11 analog pin still driven
        wr_reg(2'd1, 6'h3F);
        wr_reg(2'd2, 6'h01);
        step(3);
        bitop(1'b1, 3'd1);
        wr_reg(2'd1, 6'h00);
        chk("R7 analog out", pin_out, 6'h2E);
        chk("R11 analog oe", pin_oe, 6'h2F);
        wr_reg(2'd2, 6'h00);

        // R8: bit op beats a write; bad index ignored
        wr_reg(2'd1, 6'h3F);
        ext_val = 6'h00;
        step(3);
        @(negedge clk);
        bus_addr = 2'd0; bus_wr = 1'b1; bus_wdata = 6'h3F;
        bit_en = 1'b1; bit_set = 1'b1; bit_idx = 3'd2;
        @(negedge clk);
        bus_wr = 1'b0; bit_en = 1'b0;
        bitop(1'b1, 3'd6);
        wr_reg(2'd1, 6'h00);
        chk("R8 priority", pin_out, 6'h04);

        // R10: peripheral override
        alt_en = 6'h11; alt_oe = 6'h01; alt_out = 6'h11;
        step(1);
        chk("R10 oe", pin_oe, 6'h2F);
        chk("R10 out", pin_out, 6'h15);
        wr_reg(2'd1, 6'h3F);
        chk("R10 dir ignored", pin_oe, 6'h01);
        alt_en = 6'h00;

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule